// File: doc/BRIEF.md
# AC-link Serial Frame Controller

This block sits on the codec bit clock and handles the serial link to an audio codec in both directions. It counts out a repeating frame of 256 bit clocks. The frame has a 16-bit tag slot followed by twelve 20-bit slots. For each frame it drives a sync pulse one slot wide and shifts out the tag, an optional register command, and one left/right pair of playback samples. Every slot it does not use is sent as zeros.

On the receive side it takes the incoming serial stream apart using the same frame layout. It exposes the codec-ready flag and the most recently captured left and right samples. A mode input moves the receive sampling point one bit clock earlier, for a board where the codec's data arrives one bit ahead of the nominal alignment.

A one-cycle frame strobe marks the first bit of every frame. Sample producers and consumers use it to exchange one left/right pair per frame. A command is offered on a valid/address/data group and is acknowledged by a one-cycle pulse when a frame picks it up.

Top module: `ac_link_framer`

## Requirements
- R1: The transmit frame is 256 bit clocks long and repeats without gaps: a 16-bit tag slot (slot 0), then slots 1 to 12 of 20 bits each. `frame_strobe` is high for exactly one cycle, in the cycle that carries the first bit of each frame.
- R2: `sync` is high for exactly the 16 cycles of slot 0 in every frame. The first cycle after reset is released is the first bit of a frame.
- R3: The tag slot is sent as follows. Tag bit 15 (frame valid) is always 1. Tag bits 14 and 13 (slots 1 and 2 valid) are 1 only in a frame that carries a command. Tag bits 12 and 11 (slots 3 and 4 valid) are always 1. Tag bits 10 to 0 are 0, which includes the codec ID in bits 1:0.
- R4: Every slot is sent MSB first, with one bit per cycle. In a frame that carries a command, slot 1 is `cmd_addr` and slot 2 is `cmd_data`. In a frame without a command, slots 1 and 2 are zero. Slots 5 to 12 are always zero.
- R5: `cmd_valid` and its address and data are sampled at the clock edge that ends the last bit of a frame. When `cmd_valid` is sampled high, the next frame carries the command, and `cmd_taken` is high for one cycle in that frame's first cycle. `cmd_taken` is never high in any other cycle.
- R6: `pcm_left_in` and `pcm_right_in` are sampled at that same end-of-frame edge and sent in slots 3 and 4 of the following frame. Changes to these inputs during a frame do not affect the frame in progress.
- R7: In nominal mode (`early_rx` = 0), the receive bit for frame position p is sampled at the edge that ends the cycle at position p. `codec_ready` takes the value of incoming tag bit 15 and is updated at the edge that ends position 15.
- R8: `cap_left` takes incoming slot 3 and `cap_right` takes incoming slot 4, each assembled MSB first. Each is updated at the edge that ends the last bit of its slot (position 75 for slot 3, position 95 for slot 4). Each holds its value until the same point in the next frame, so at `frame_strobe` both outputs belong to the frame just ended.
- R9: With `early_rx` = 1, the receive bit for position p is sampled one cycle earlier, at the edge that ends position p-1. The bit for position 0 is sampled at the edge that ends position 255 of the previous frame. As a result, `codec_ready`, `cap_left` and `cap_right` each update one cycle sooner than in nominal mode.
- R10: While `rst_n` is low, `sync`, `sdata_out`, `frame_strobe`, `cmd_taken`, `codec_ready`, `cap_left` and `cap_right` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Codec bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| early_rx | input | 1 | 1 = sample receive data one bit clock earlier |
| cmd_valid | input | 1 | A register command is pending |
| cmd_addr | input | 20 | Slot 1 word of the pending command |
| cmd_data | input | 20 | Slot 2 word of the pending command |
| cmd_taken | output | 1 | One-cycle pulse: the pending command was loaded into the frame now starting |
| pcm_left_in | input | 20 | Left playback sample for the next frame |
| pcm_right_in | input | 20 | Right playback sample for the next frame |
| frame_strobe | output | 1 | High during the first bit of each frame |
| sync | output | 1 | Frame sync to the codec, high during slot 0 |
| sdata_out | output | 1 | Serial data to the codec |
| sdata_in | input | 1 | Serial data from the codec |
| codec_ready | output | 1 | Registered codec-ready flag from incoming tag bit 15 |
| cap_left | output | 20 | Last captured left sample (incoming slot 3) |
| cap_right | output | 20 | Last captured right sample (incoming slot 4) |

## Verification
Every transmit output carries the frame position of the cycle it is seen in. After reset is released, the first rising edge starts position 0, so `sync`, `frame_strobe`, `sdata_out` and `cmd_taken` can be predicted purely from a position count. The command and samples a frame carries are the input values present at the edge that ends the previous frame's position 255. Receive results appear in the cycle after the edge that samples the last bit of their field: positions 16, 76 and 96 in nominal mode, and positions 15, 75 and 95 in early mode. The bench's reference model keeps this same position count. It updates its expected values at each rising edge and compares every output at the following falling edge. Its serial driver places each codec bit either at its own position or one position early, following the mode.

// File: rtl/alf_pkg.sv
package alf_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int NUM_SLOTS  = 13;
  localparam int FRAME_LEN  = TAG_W + (NUM_SLOTS - 1) * SLOT_W;
  localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);
  localparam int BIT_IDX_W  = $clog2(SLOT_W);

  localparam int SLOT_ADDR  = 1;
  localparam int SLOT_DATA  = 2;
  localparam int SLOT_LEFT  = 3;
  localparam int SLOT_RIGHT = 4;

  typedef logic [SLOT_IDX_W-1:0] slot_idx_t;
  typedef logic [BIT_IDX_W-1:0]  bit_idx_t;
  typedef logic [SLOT_W-1:0]     word_t;

  // Position inside the frame: slot number and index of the bit within it
  // (counts down, so the index is also the bit position of the slot word).
  typedef struct packed {
    slot_idx_t slot;
    bit_idx_t  bitn;
  } frame_pos_t;
endpackage

// File: rtl/alf_timing.sv
module alf_timing
  import alf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  output frame_pos_t pos_q,
  output frame_pos_t pos_d,
  output logic       last_bit,
  output logic       sync_q,
  output logic       strobe_q
);
  localparam slot_idx_t LAST_SLOT = slot_idx_t'(NUM_SLOTS - 1);
  localparam bit_idx_t  TAG_TOP   = bit_idx_t'(TAG_W - 1);
  localparam bit_idx_t  WORD_TOP  = bit_idx_t'(SLOT_W - 1);

  logic sync_d;
  logic strobe_d;

  // Next-state: walk slot 0 (16 bits) then slots 1..12 (20 bits each).
  always_comb begin
    last_bit = (pos_q.slot == LAST_SLOT) && (pos_q.bitn == '0);
    pos_d    = pos_q;
    if (last_bit) begin
      pos_d.slot = '0;
      pos_d.bitn = TAG_TOP;
    end else if (pos_q.bitn == '0) begin
      pos_d.slot = pos_q.slot + slot_idx_t'(1);
      pos_d.bitn = WORD_TOP;
    end else begin
      pos_d.bitn = pos_q.bitn - bit_idx_t'(1);
    end
    sync_d   = (pos_d.slot == '0);
    strobe_d = last_bit;
  end

  // Reset parks the counter on the final bit so the first edge opens a frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q.slot <= LAST_SLOT;
      pos_q.bitn <= '0;
      sync_q     <= 1'b0;
      strobe_q   <= 1'b0;
    end else begin
      pos_q      <= pos_d;
      sync_q     <= sync_d;
      strobe_q   <= strobe_d;
    end
  end
endmodule

// File: rtl/alf_tx.sv
module alf_tx
  import alf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  frame_pos_t pos_d,
  input  logic       cmd_valid,
  input  word_t      cmd_addr,
  input  word_t      cmd_data,
  input  word_t      pcm_left,
  input  word_t      pcm_right,
  output logic       sdo_q,
  output logic       cmd_taken_q
);
  logic  has_cmd_q, has_cmd_d;
  word_t addr_q, addr_d;
  word_t data_q, data_d;
  word_t left_q, left_d;
  word_t right_q, right_d;
  logic [TAG_W-1:0] tag_d;
  word_t words [NUM_SLOTS];
  logic  sdo_d;

  // Frame contents: new values are taken on the last bit of a frame and
  // used at once for the first bit of the next one.
  always_comb begin
    has_cmd_d = has_cmd_q;
    addr_d    = addr_q;
    data_d    = data_q;
    left_d    = left_q;
    right_d   = right_q;
    if (load) begin
      has_cmd_d = cmd_valid;
      addr_d    = cmd_valid ? cmd_addr : '0;
      data_d    = cmd_valid ? cmd_data : '0;
      left_d    = pcm_left;
      right_d   = pcm_right;
    end
    tag_d = {1'b1, has_cmd_d, has_cmd_d, 2'b11, {(TAG_W-7){1'b0}}, 2'b00};
  end

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      if (s == 0) begin : g_tag
        assign words[s] = {{(SLOT_W-TAG_W){1'b0}}, tag_d};
      end else if (s == SLOT_ADDR) begin : g_addr
        assign words[s] = addr_d;
      end else if (s == SLOT_DATA) begin : g_data
        assign words[s] = data_d;
      end else if (s == SLOT_LEFT) begin : g_left
        assign words[s] = left_d;
      end else if (s == SLOT_RIGHT) begin : g_right
        assign words[s] = right_d;
      end else begin : g_pad
        assign words[s] = '0;
      end
    end
  endgenerate

  always_comb begin
    if (int'(pos_d.slot) < NUM_SLOTS) sdo_d = words[pos_d.slot][pos_d.bitn];
    else                              sdo_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      has_cmd_q   <= 1'b0;
      addr_q      <= '0;
      data_q      <= '0;
      left_q      <= '0;
      right_q     <= '0;
      sdo_q       <= 1'b0;
      cmd_taken_q <= 1'b0;
    end else begin
      if (load) begin
        has_cmd_q <= has_cmd_d;
        addr_q    <= addr_d;
        data_q    <= data_d;
        left_q    <= left_d;
        right_q   <= right_d;
      end
      sdo_q       <= sdo_d;
      cmd_taken_q <= load & cmd_valid;
    end
  end
endmodule

// File: rtl/alf_rx.sv
module alf_rx
  import alf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       early,
  input  logic       sdi,
  input  frame_pos_t pos_q,
  input  frame_pos_t pos_d,
  output logic       ready_q,
  output word_t      left_q,
  output word_t      right_q
);
  frame_pos_t samp;
  word_t      sh_q, sh_d;
  logic       slot_end;
  logic       take_ready, take_left, take_right;

  // In early mode the bit on the wire already belongs to the next position.
  always_comb begin
    samp       = early ? pos_d : pos_q;
    sh_d       = {sh_q[SLOT_W-2:0], sdi};
    slot_end   = (samp.bitn == '0);
    take_ready = slot_end && (int'(samp.slot) == 0);
    take_left  = slot_end && (int'(samp.slot) == SLOT_LEFT);
    take_right = slot_end && (int'(samp.slot) == SLOT_RIGHT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      ready_q <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      sh_q <= sh_d;
      if (take_ready) ready_q <= sh_d[TAG_W-1];
      if (take_left)  left_q  <= sh_d;
      if (take_right) right_q <= sh_d;
    end
  end
endmodule

// File: rtl/ac_link_framer.sv
module ac_link_framer
  import alf_pkg::*;
(
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              early_rx,
  input  logic              cmd_valid,
  input  logic [SLOT_W-1:0] cmd_addr,
  input  logic [SLOT_W-1:0] cmd_data,
  output logic              cmd_taken,
  input  logic [SLOT_W-1:0] pcm_left_in,
  input  logic [SLOT_W-1:0] pcm_right_in,
  output logic              frame_strobe,
  output logic              sync,
  output logic              sdata_out,
  input  logic              sdata_in,
  output logic              codec_ready,
  output logic [SLOT_W-1:0] cap_left,
  output logic [SLOT_W-1:0] cap_right
);
  frame_pos_t pos_q;
  frame_pos_t pos_d;
  logic       last_bit;

  alf_timing u_timing (
    .clk      (bit_clk),
    .rst_n    (rst_n),
    .pos_q    (pos_q),
    .pos_d    (pos_d),
    .last_bit (last_bit),
    .sync_q   (sync),
    .strobe_q (frame_strobe)
  );

  alf_tx u_tx (
    .clk         (bit_clk),
    .rst_n       (rst_n),
    .load        (last_bit),
    .pos_d       (pos_d),
    .cmd_valid   (cmd_valid),
    .cmd_addr    (cmd_addr),
    .cmd_data    (cmd_data),
    .pcm_left    (pcm_left_in),
    .pcm_right   (pcm_right_in),
    .sdo_q       (sdata_out),
    .cmd_taken_q (cmd_taken)
  );

  alf_rx u_rx (
    .clk     (bit_clk),
    .rst_n   (rst_n),
    .early   (early_rx),
    .sdi     (sdata_in),
    .pos_q   (pos_q),
    .pos_d   (pos_d),
    .ready_q (codec_ready),
    .left_q  (cap_left),
    .right_q (cap_right)
  );
endmodule

// File: rtl/alf_checker.sv
module alf_checker
  import alf_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic sync,
  input logic frame_strobe,
  input logic sdata_out,
  input logic cmd_taken
);
  logic [4:0] ck_run;
  logic [8:0] ck_pos;
  logic       ck_seen;

  // ck_run: consecutive sync-high cycles so far; ck_pos: position of the
  // current cycle once a strobe has been seen (strobe cycle itself is 0).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_run  <= '0;
      ck_pos  <= '0;
      ck_seen <= 1'b0;
    end else begin
      ck_run  <= sync ? ((ck_run == 5'd31) ? ck_run : ck_run + 5'd1) : 5'd0;
      ck_pos  <= frame_strobe ? 9'd1 : ((ck_pos == 9'h1FF) ? ck_pos : ck_pos + 9'd1);
      ck_seen <= ck_seen | frame_strobe;
    end
  end

  assert_sync_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync) |-> ck_run == 5'(TAG_W));

  assert_sync_not_long_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> ck_run < 5'(TAG_W));

  assert_strobe_opens_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> $rose(sync));

  assert_frame_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && ck_seen) |-> ck_pos == 9'(FRAME_LEN));

  assert_frame_valid_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> sdata_out);

  assert_tag_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_seen && !frame_strobe && ck_pos >= 9'd5 && ck_pos < 9'(TAG_W)) |-> !sdata_out);

  assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_seen && !frame_strobe && ck_pos >= 9'(TAG_W + 4*SLOT_W) && ck_pos < 9'(FRAME_LEN))
      |-> !sdata_out);

  assert_taken_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_taken |-> frame_strobe);

  assert_taken_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_taken |=> !cmd_taken);
endmodule

bind ac_link_framer alf_checker u_alf_checker (
  .clk          (bit_clk),
  .rst_n        (rst_n),
  .sync         (sync),
  .frame_strobe (frame_strobe),
  .sdata_out    (sdata_out),
  .cmd_taken    (cmd_taken)
);

// File: tb/tb_ac_link_framer.sv
module tb_ac_link_framer;
  localparam int CLK_HALF   = 2;
  localparam int RUN_FRAMES = 15;
  localparam int WATCHDOG   = 200000;

  logic        bit_clk = 1'b0;
  logic        rst_n;
  logic        early_rx;
  logic        cmd_valid;
  logic [19:0] cmd_addr, cmd_data;
  logic        cmd_taken;
  logic [19:0] pcm_left_in, pcm_right_in;
  logic        frame_strobe, sync, sdata_out, sdata_in, codec_ready;
  logic [19:0] cap_left, cap_right;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // Reference model state
  int          mpos;
  int          fnum;
  logic        fr_cmd;
  logic [19:0] fr_addr, fr_data, fr_l, fr_r;
  logic        cur_rdy, nxt_rdy;
  logic [19:0] cur_l, cur_r, nxt_l, nxt_r;
  logic        exp_rdy;
  logic [19:0] exp_l, exp_r;

  always #CLK_HALF bit_clk = ~bit_clk;

  ac_link_framer dut (
    .bit_clk(bit_clk), .rst_n(rst_n), .early_rx(early_rx),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_taken(cmd_taken),
    .pcm_left_in(pcm_left_in), .pcm_right_in(pcm_right_in), .frame_strobe(frame_strobe),
    .sync(sync), .sdata_out(sdata_out), .sdata_in(sdata_in), .codec_ready(codec_ready),
    .cap_left(cap_left), .cap_right(cap_right)
  );

  // Codec-side frame contents per frame number
  function automatic logic rdy_of(int n);
    return (n % 4) != 3;
  endfunction
  function automatic logic [19:0] lft_of(int n);
    if (n == 2) return 20'h80000;
    if (n == 3) return 20'hFFFFF;
    return 20'((n * 37 + 11) * 20'h0B3C5) ^ 20'h5A0F3;
  endfunction
  function automatic logic [19:0] rgt_of(int n);
    if (n == 2) return 20'h00001;
    if (n == 3) return 20'h00000;
    return 20'((n * 53 + 7) * 20'h1D2E9) ^ 20'hA3C05;
  endfunction

  function automatic logic rx_bit(logic r, logic [19:0] l, logic [19:0] rr, int p);
    logic [15:0] tag;
    logic [19:0] w;
    int s, k;
    tag = {r, 4'b1111, 11'b0};
    if (p < 16) return tag[15-p];
    s = (p - 16) / 20 + 1;
    k = (p - 16) % 20;
    w = (s == 3) ? l : ((s == 4) ? rr : 20'h6C3A9);
    return w[19-k];
  endfunction

  function automatic logic [19:0] tx_word(int s);
    case (s)
      1: return fr_cmd ? fr_addr : 20'h0;
      2: return fr_cmd ? fr_data : 20'h0;
      3: return fr_l;
      4: return fr_r;
      default: return 20'h0;
    endcase
  endfunction

  function automatic logic tx_bit(int p);
    logic [15:0] tag;
    logic [19:0] w;
    int s, k;
    tag = {1'b1, fr_cmd, fr_cmd, 2'b11, 11'b0};
    if (p < 16) return tag[15-p];
    s = (p - 16) / 20 + 1;
    k = (p - 16) % 20;
    w = tx_word(s);
    return w[19-k];
  endfunction

  function automatic string tx_req(int p);
    int s;
    if (p < 16) return "R3";
    s = (p - 16) / 20 + 1;
    if (s == 3 || s == 4) return "R6";
    return "R4";
  endfunction

  // Behavioural model, advanced on every rising edge
  always @(posedge bit_clk) begin
    int q;
    if (!rst_n) begin
      mpos = 255; fnum = 0;
      fr_cmd = 0; fr_addr = 0; fr_data = 0; fr_l = 0; fr_r = 0;
      exp_rdy = 0; exp_l = 0; exp_r = 0;
      cur_rdy = rdy_of(0); cur_l = lft_of(0); cur_r = rgt_of(0);
      nxt_rdy = rdy_of(1); nxt_l = lft_of(1); nxt_r = rgt_of(1);
    end else begin
      q = early_rx ? mpos + 1 : mpos;
      if (q == 15) exp_rdy = cur_rdy;
      if (q == 75) exp_l = cur_l;
      if (q == 95) exp_r = cur_r;
      mpos = (mpos + 1) % 256;
      if (mpos == 0) begin
        fr_cmd = cmd_valid; fr_addr = cmd_addr; fr_data = cmd_data;
        fr_l = pcm_left_in; fr_r = pcm_right_in;
        fnum = fnum + 1;
        cur_rdy = nxt_rdy; cur_l = nxt_l; cur_r = nxt_r;
        nxt_rdy = rdy_of(fnum + 1); nxt_l = lft_of(fnum + 1); nxt_r = rgt_of(fnum + 1);
      end
    end
  end

  task automatic cmp(string req, string what, logic [19:0] act, logic [19:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s frame %0d pos %0d: actual %h expected %h",
               req, what, fnum, mpos, act, exp);
    end
  endtask

  task automatic check_cycle();
    vectors++;
    cmp("R2", "sync", sync, 20'(mpos < 16));
    cmp("R1", "frame_strobe", frame_strobe, 20'(mpos == 0));
    cmp(tx_req(mpos), "sdata_out", sdata_out, 20'(tx_bit(mpos)));
    cmp("R5", "cmd_taken", cmd_taken, 20'((mpos == 0) && fr_cmd));
    cmp(early_rx ? "R9" : "R7", "codec_ready", codec_ready, 20'(exp_rdy));
    cmp(early_rx ? "R9" : "R8", "cap_left", cap_left, exp_l);
    cmp(early_rx ? "R9" : "R8", "cap_right", cap_right, exp_r);
  endtask

  task automatic drive_cycle();
    if (mpos == 255) early_rx = (fnum >= 5 && fnum < 10);
    if (cmd_taken) cmd_valid = 1'b0;
    if (!cmd_valid && ((mpos == 200 && (fnum % 3) == 1) || (mpos == 255 && fnum == 12))) begin
      cmd_valid = 1'b1;
      cmd_addr  = 20'(fnum * 4096 + 20'h02000);
      cmd_data  = 20'(fnum * 20'h01111) ^ 20'hF0F00;
    end
    if (mpos == 0) begin
      pcm_left_in  = (fnum == 6) ? 20'hFFFFF : 20'((fnum + 3) * 20'h1357B);
      pcm_right_in = (fnum == 6) ? 20'h00000 : (20'((fnum + 5) * 20'h2468D) ^ 20'h80000);
    end
    if (early_rx)
      sdata_in = (mpos == 255) ? rx_bit(nxt_rdy, nxt_l, nxt_r, 0)
                               : rx_bit(cur_rdy, cur_l, cur_r, mpos + 1);
    else
      sdata_in = rx_bit(cur_rdy, cur_l, cur_r, mpos);
  endtask

  initial begin
    rst_n = 1'b0; early_rx = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_data = '0;
    pcm_left_in = '0; pcm_right_in = '0; sdata_in = 1'b0;
    repeat (3) @(negedge bit_clk);
    // R10: outputs held at zero during reset
    vectors++;
    cmp("R10", "sync", sync, 20'h0);
    cmp("R10", "sdata_out", sdata_out, 20'h0);
    cmp("R10", "frame_strobe", frame_strobe, 20'h0);
    cmp("R10", "cmd_taken", cmd_taken, 20'h0);
    cmp("R10", "codec_ready", codec_ready, 20'h0);
    cmp("R10", "cap_left", cap_left, 20'h0);
    cmp("R10", "cap_right", cap_right, 20'h0);
    rst_n = 1'b1;
    while (fnum < RUN_FRAMES) begin
      @(negedge bit_clk);
      check_cycle();
      drive_cycle();
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(WATCHDOG * 2 * CLK_HALF);
    if (!finished) begin
      miscompares++;
      $display("FAIL R1 watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule